// File: doc/BRIEF.md
# Lockable Block Memory Write Controller

This controller sits in front of an array of 32-bit words and serves read and write commands. Each command carries an 8-bit block address. The address decides which write rule applies.

- **User region.** Words are rewritten with an erase phase followed by a program phase.
- **Lockable blocks.** The lowest blocks of the user region can be frozen for good by clearing bits in a lock field.
- **System word.** The lock field lives in a single system word at the top of the address space. That word is never erased. Every write to it is a bitwise AND, so its bits only ever move from 1 to 0.

A client pulses a read or write strobe while the controller is idle. A write keeps `busy` high for its fixed erase and program time. When the write ends, `done` pulses, together with `rejected` if the controller refused it. Read data is registered and appears on the cycle after the request. Erase and program times are modelled as fixed cycle counts.

Top module: `blkmem_wctl`

## Requirements
- R1: Block addresses 7 to 127 form the user region. Each holds a 32-bit word that a read returns on `rd_data` one cycle after the request edge.
- R2: An accepted write to a user block keeps `busy` high for exactly 8 cycles: 4 erase cycles, then 4 program cycles. `done` then pulses for one cycle with `busy` low. The stored word equals the written data, regardless of the old contents.
- R3: The lock field is bits [7:0] of the system word at address 255. A bit at 0 means protected. Bit i protects block 7+i for i from 0 to 7, and bit 7 also protects block 15. A write to a protected block is rejected and leaves the block unchanged.
- R4: Lock bits never return from 0 to 1, whatever data is written to address 255.
- R5: A write to address 255 does no erase. It keeps `busy` high for 4 cycles and stores the old word ANDed with the written data.
- R6: Once the word at address 255 is all zeros, a further write to it is rejected and the word stays zero.
- R7: A rejected write, including any write to addresses 0 to 6 or 128 to 254, produces `done` and `rejected` together for one cycle on the cycle after the request edge. `busy` stays low and memory is unchanged.
- R8: While `busy` is high, read and write strobes are ignored. `rd_data` keeps its value and no other block changes.
- R9: A read from addresses 0 to 6 or 128 to 254 returns 32'hFFFF_FFFF.
- R10: After reset, every user block and the word at address 255 read as 32'hFFFF_FFFF. `busy`, `done` and `rejected` are low, and `rd_data` is zero.
- R11: When both strobes are high in the same idle cycle, the write is performed and the read is ignored, so `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe |
| cmd_addr | input | 8 | Block address |
| cmd_wdata | input | 32 | Write data |
| busy | output | 1 | An erase or program operation is in progress |
| done | output | 1 | One-cycle pulse when a write finishes or is refused |
| rejected | output | 1 | Set with `done` when the write was refused |
| rd_data | output | 32 | Registered read data |

## Verification
The embedded assertions check several rules on every cycle:
- the system word and its lock bits only ever lose ones, and an all-zero system word stays zero (R4, R5, R6);
- `done` and `busy` are never high together, and `busy` holds until the final program cycle (R2, R8);
- every program phase that follows an erase phase is preceded by the erase strobe (R2);
- a refused write produces a rejection pulse without starting any operation, and an unmapped read yields all ones (R3, R7, R9).

Only the directed scenarios can show that the right data ends up in the right block, because that needs a read-back. The same holds for the exact busy lengths, the lock-bit-to-block mapping including the shared bit for block 15, and the fact that strobes during busy, or a read paired with a write, leave no trace.

// File: rtl/blkmem_pkg.sv
package blkmem_pkg;

  typedef enum logic [1:0] {RG_NONE, RG_USER, RG_SYS} region_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG} phase_e;

  // Classify a block address into one of the three regions.
  function automatic region_e region_of(input int a, input int lo, input int hi, input int sys);
    if (a == sys) return RG_SYS;
    if (a >= lo && a <= hi) return RG_USER;
    return RG_NONE;
  endfunction

  // Lock bit guarding a block, or -1 when the block is not lockable.
  // The last lock bit also covers every lockable block above its own slot.
  function automatic int lock_slot(input int a, input int lo, input int lock_hi, input int nbits);
    int s;
    if (a < lo || a > lock_hi) return -1;
    s = a - lo;
    if (s > nbits - 1) s = nbits - 1;
    return s;
  endfunction

endpackage

// File: rtl/blkmem_decode.sv
module blkmem_decode
  import blkmem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int USER_LO   = 7,
  parameter int USER_HI   = 127,
  parameter int LOCK_HI   = 15,
  parameter int LOCK_BITS = 8,
  parameter int SYS_ADDR  = 255,
  parameter int IDX_W     = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] sys_word,
  output region_e           region,
  output logic              locked,
  output logic              exhausted,
  output logic              write_ok,
  output logic [IDX_W-1:0]  user_idx
);

  int slot;

  always_comb begin
    region = region_of(int'(addr), USER_LO, USER_HI, SYS_ADDR);
    slot   = lock_slot(int'(addr), USER_LO, LOCK_HI, LOCK_BITS);
    locked = 1'b0;
    for (int i = 0; i < LOCK_BITS; i++) begin
      if (slot == i && !sys_word[i]) locked = 1'b1;
    end
    exhausted = (sys_word == '0);
    write_ok  = ((region == RG_USER) && !locked) ||
                ((region == RG_SYS) && !exhausted);
    user_idx  = (region == RG_USER) ? IDX_W'(int'(addr) - USER_LO) : '0;
  end

endmodule

// File: rtl/blkmem_seq.sv
module blkmem_seq
  import blkmem_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 7,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  region_e           region,
  input  logic              write_ok,
  input  logic [IDX_W-1:0]  user_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic              rejected,
  output logic              erase_fire,
  output logic              prog_fire,
  output logic              prog_sys,
  output logic              rd_fire,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic [DATA_W-1:0] tgt_data
);

  localparam int CNT_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             accept_wr;

  assign busy       = (phase != PH_IDLE);
  assign accept_wr  = cmd_wr && !busy;
  assign rd_fire    = cmd_rd && !cmd_wr && !busy;
  assign erase_fire = (phase == PH_ERASE) && (cnt == ERASE_LAST);
  assign prog_fire  = (phase == PH_PROG) && (cnt == PROG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      rejected <= 1'b0;
      prog_sys <= 1'b0;
      tgt_idx  <= '0;
      tgt_data <= '0;
    end else begin
      done     <= 1'b0;
      rejected <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept_wr) begin
            if (!write_ok) begin
              done     <= 1'b1;
              rejected <= 1'b1;
            end else begin
              tgt_idx  <= user_idx;
              tgt_data <= wdata;
              prog_sys <= (region == RG_SYS);
              cnt      <= '0;
              phase    <= (region == RG_SYS) ? PH_PROG : PH_ERASE;
            end
          end
        end
        PH_ERASE: begin
          if (erase_fire) begin
            cnt   <= '0;
            phase <= PH_PROG;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_PROG: begin
          if (prog_fire) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: a program phase entered from an erase phase follows an erase strobe
  assert_erase_precedes_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PROG && $past(phase) == PH_ERASE) |-> $past(erase_fire));

  // R8: done never overlaps an operation in progress
  assert_done_outside_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, busy}));

  // R8: busy holds until the final program cycle
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_fire) |=> busy);

  // R5: the system word is never erased
  assert_sys_no_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ERASE) |-> !prog_sys);

endmodule

// File: rtl/blkmem_store.sv
module blkmem_store
  import blkmem_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int USER_N    = 121,
  parameter int IDX_W     = 7,
  parameter int LOCK_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_fire,
  input  logic              prog_fire,
  input  logic              prog_sys,
  input  logic [IDX_W-1:0]  tgt_idx,
  input  logic [DATA_W-1:0] tgt_data,
  input  logic              rd_fire,
  input  region_e           rd_region,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] sys_word
);

  logic [DATA_W-1:0] mem [USER_N];
  logic [DATA_W-1:0] sys_q;

  assign sys_word = sys_q;

  // Merge rule for the system word: bits can only be cleared.
  function automatic logic [DATA_W-1:0] and_merge(input logic [DATA_W-1:0] old_w,
                                                  input logic [DATA_W-1:0] new_w);
    return old_w & new_w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < USER_N; i++) mem[i] <= '1;
    end else if (int'(tgt_idx) < USER_N) begin
      if (erase_fire) mem[tgt_idx] <= '1;
      else if (prog_fire && !prog_sys) mem[tgt_idx] <= tgt_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_q <= '1;
    else if (prog_fire && prog_sys) sys_q <= and_merge(sys_q, tgt_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_fire) begin
      case (rd_region)
        RG_USER: rd_data <= (int'(rd_idx) < USER_N) ? mem[rd_idx] : '1;
        RG_SYS:  rd_data <= sys_q;
        default: rd_data <= '1;
      endcase
    end
  end

  // R5: the system word only ever loses ones
  assert_sys_and_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q & ~$past(sys_q)) == '0);

  // R4: lock bits never return to the unprotected state
  assert_lock_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_q[LOCK_BITS-1:0] & ~$past(sys_q[LOCK_BITS-1:0])) == '0);

  // R6: an exhausted system word stays exhausted
  assert_exhausted_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sys_q) == '0) |-> (sys_q == '0));

endmodule

// File: rtl/blkmem_wctl.sv
module blkmem_wctl
  import blkmem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int USER_LO   = 7,
  parameter int USER_HI   = 127,
  parameter int LOCK_HI   = 15,
  parameter int LOCK_BITS = 8,
  parameter int SYS_ADDR  = 255,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              rejected,
  output logic [DATA_W-1:0] rd_data
);

  localparam int USER_N = USER_HI - USER_LO + 1;
  localparam int IDX_W  = $clog2(USER_N);

  region_e           region;
  logic              locked;
  logic              exhausted;
  logic              write_ok;
  logic [IDX_W-1:0]  user_idx;
  logic [DATA_W-1:0] sys_word;
  logic              erase_fire;
  logic              prog_fire;
  logic              prog_sys;
  logic              rd_fire;
  logic [IDX_W-1:0]  tgt_idx;
  logic [DATA_W-1:0] tgt_data;

  blkmem_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_LO(USER_LO), .USER_HI(USER_HI),
    .LOCK_HI(LOCK_HI), .LOCK_BITS(LOCK_BITS), .SYS_ADDR(SYS_ADDR), .IDX_W(IDX_W)
  ) u_decode (
    .addr      (cmd_addr),
    .sys_word  (sys_word),
    .region    (region),
    .locked    (locked),
    .exhausted (exhausted),
    .write_ok  (write_ok),
    .user_idx  (user_idx)
  );

  blkmem_seq #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_rd     (cmd_rd),
    .cmd_wr     (cmd_wr),
    .region     (region),
    .write_ok   (write_ok),
    .user_idx   (user_idx),
    .wdata      (cmd_wdata),
    .busy       (busy),
    .done       (done),
    .rejected   (rejected),
    .erase_fire (erase_fire),
    .prog_fire  (prog_fire),
    .prog_sys   (prog_sys),
    .rd_fire    (rd_fire),
    .tgt_idx    (tgt_idx),
    .tgt_data   (tgt_data)
  );

  blkmem_store #(
    .DATA_W(DATA_W), .USER_N(USER_N), .IDX_W(IDX_W), .LOCK_BITS(LOCK_BITS)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase_fire (erase_fire),
    .prog_fire  (prog_fire),
    .prog_sys   (prog_sys),
    .tgt_idx    (tgt_idx),
    .tgt_data   (tgt_data),
    .rd_fire    (rd_fire),
    .rd_region  (region),
    .rd_idx     (user_idx),
    .rd_data    (rd_data),
    .sys_word   (sys_word)
  );

  // R3: an idle write to a locked block is refused on the next cycle without starting
  assert_locked_rejected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && region == RG_USER && locked) |=> (rejected && !busy));

  // R6: an idle write to an exhausted system word is refused
  assert_exhausted_rejected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && region == RG_SYS && exhausted) |=> (rejected && !busy));

  // R7: an idle write to an unmapped address is refused
  assert_unmapped_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && region == RG_NONE) |=> (rejected && done && !busy));

  // R9: an unmapped read yields all ones
  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && region == RG_NONE) |=> (rd_data == '1));

endmodule

// File: tb/blkmem_wctl_tb.sv
`timescale 1ns/1ps
module blkmem_wctl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_rd = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [7:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        busy, done, rejected;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  blkmem_wctl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rejected(rejected), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue a write, count busy cycles until done, then check length and reject flag.
  task automatic write_op(input logic [7:0] a, input logic [31:0] d,
                          input int exp_busy, input bit exp_rej, input string tag);
    int nb = 0;
    bit seen = 1'b0;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cmd_wr = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (done) begin seen = 1'b1; break; end
      if (busy) nb++;
      @(negedge clk);
    end
    chk(seen && !busy, {tag, " done"}, 32'(seen), 32'd1);
    chk(nb == exp_busy, {tag, " busy length"}, 32'(nb), 32'(exp_busy));
    chk(rejected == exp_rej, {tag, " rejected"}, 32'(rejected), 32'(exp_rej));
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cmd_rd = 1'b1; cmd_addr = a;
    @(posedge clk);
    @(negedge clk);
    cmd_rd = 1'b0;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !rejected, "R10 flags after reset", {29'd0, busy, done, rejected}, 32'd0);
    chk(rd_data == 32'd0, "R10 rd_data after reset", rd_data, 32'd0);
    read_chk(8'd7, 32'hFFFF_FFFF, "R10 block 7 erased");
    read_chk(8'd127, 32'hFFFF_FFFF, "R10 block 127 erased");
    read_chk(8'd255, 32'hFFFF_FFFF, "R10 system word ones");
  endtask

  task automatic t_user_write;
    write_op(8'd20, 32'h1234_5678, 8, 1'b0, "R2 user write");
    read_chk(8'd20, 32'h1234_5678, "R1 read back block 20");
    write_op(8'd20, 32'h0000_FFFF, 8, 1'b0, "R2 rewrite");
    read_chk(8'd20, 32'h0000_FFFF, "R2 rewrite replaces not ANDs");
    write_op(8'd127, 32'hA5A5_5A5A, 8, 1'b0, "R1 top block write");
    read_chk(8'd127, 32'hA5A5_5A5A, "R1 read back block 127");
    read_chk(8'd20, 32'h0000_FFFF, "R1 block 20 kept");
  endtask

  task automatic t_unmapped;
    write_op(8'd3, 32'h0, 0, 1'b1, "R7 write addr 3");
    write_op(8'd200, 32'h0, 0, 1'b1, "R7 write addr 200");
    read_chk(8'd3, 32'hFFFF_FFFF, "R9 read addr 3");
    read_chk(8'd128, 32'hFFFF_FFFF, "R9 read addr 128");
    read_chk(8'd254, 32'hFFFF_FFFF, "R9 read addr 254");
  endtask

  task automatic t_busy_ignore;
    logic [31:0] prev;
    read_chk(8'd127, 32'hA5A5_5A5A, "R8 preload rd_data");
    prev = rd_data;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_addr = 8'd40; cmd_wdata = 32'hCAFE_0040;
    @(posedge clk);
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(busy, "R8 busy after accept", 32'(busy), 32'd1);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_addr = 8'd41; cmd_wdata = 32'h0000_0041;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_rd = 1'b1; cmd_addr = 8'd40;
    @(negedge clk);
    cmd_rd = 1'b0;
    chk(rd_data == prev, "R8 read during busy ignored", rd_data, prev);
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    read_chk(8'd41, 32'hFFFF_FFFF, "R8 write during busy ignored");
    read_chk(8'd40, 32'hCAFE_0040, "R8 first write stored");
  endtask

  task automatic t_rd_wr_same;
    read_chk(8'd20, 32'h0000_FFFF, "R11 preload");
    @(negedge clk);
    cmd_wr = 1'b1; cmd_rd = 1'b1; cmd_addr = 8'd30; cmd_wdata = 32'h3030_3030;
    @(posedge clk);
    @(negedge clk);
    cmd_wr = 1'b0; cmd_rd = 1'b0;
    chk(rd_data == 32'h0000_FFFF, "R11 read ignored", rd_data, 32'h0000_FFFF);
    chk(busy, "R11 write started", 32'(busy), 32'd1);
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    read_chk(8'd30, 32'h3030_3030, "R11 write performed");
  endtask

  task automatic t_lock;
    write_op(8'd7, 32'h7777_0007, 8, 1'b0, "R3 block 7 before lock");
    write_op(8'd255, 32'hFFFF_FFFE, 4, 1'b0, "R5 clear lock bit 0");
    read_chk(8'd255, 32'hFFFF_FFFE, "R5 system word AND");
    write_op(8'd7, 32'h0000_0001, 0, 1'b1, "R3 write locked block 7");
    read_chk(8'd7, 32'h7777_0007, "R3 locked block 7 unchanged");
    write_op(8'd8, 32'h0000_0008, 8, 1'b0, "R3 block 8 still open");
    read_chk(8'd8, 32'h0000_0008, "R3 block 8 stored");
    write_op(8'd255, 32'hFFFF_FF7F, 4, 1'b0, "R5 clear lock bit 7");
    read_chk(8'd255, 32'hFFFF_FF7E, "R5 AND accumulates");
    write_op(8'd14, 32'h0, 0, 1'b1, "R3 block 14 locked by bit 7");
    write_op(8'd15, 32'h0, 0, 1'b1, "R3 block 15 shares bit 7");
    read_chk(8'd15, 32'hFFFF_FFFF, "R3 block 15 unchanged");
    write_op(8'd16, 32'h1616_1616, 8, 1'b0, "R3 block 16 not lockable");
    write_op(8'd255, 32'hFFFF_FFFF, 4, 1'b0, "R4 try to unlock");
    read_chk(8'd255, 32'hFFFF_FF7E, "R4 lock bits stay cleared");
  endtask

  task automatic t_exhaust;
    write_op(8'd255, 32'h0, 4, 1'b0, "R6 clear all system bits");
    read_chk(8'd255, 32'h0, "R6 system word zero");
    write_op(8'd255, 32'hFFFF_FFFF, 0, 1'b1, "R6 write exhausted word");
    read_chk(8'd255, 32'h0, "R6 exhausted word stays zero");
    write_op(8'd9, 32'h0, 0, 1'b1, "R3 block 9 locked after clear");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_user_write();
    t_unmapped();
    t_busy_ignore();
    t_rd_wr_same();
    t_lock();
    t_exhaust();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule